// File: doc/BRIEF.md
# PCM Voice Slot Serializer and Deserializer

This block carries audio samples for up to three full-duplex voice channels across a single time-slotted PCM data line that other devices share. A separate frame timing unit supplies one-cycle strobes that mark each rising and each falling edge of the bit clock, together with the current slot number and the bit position (0 to 15) inside that slot. Each channel is given one slot. In that slot the block sends the channel's transmit sample and captures a receive sample into the same channel's register.

A slot is 16 bits wide, and a sample uses 13 of them. For each channel, software-facing configuration sets the slot number, whether the 13 sample bits sit at the start or at the end of the slot, whether they travel most or least significant bit first, and what goes into the three spare bits on output. The spare bits are discarded on input. The default format is two's complement data, placed at the start of the slot, sent most significant bit first, with zero fill. In any slot that no enabled channel owns, the output enable stays low so that the pad is released. An owned slot releases the pad on the falling edge of its last bit.

The block holds one sample per direction per channel. Its transmit inputs are read once, at the start of the owned slot. Its receive outputs are updated, with a one-cycle valid pulse, after the falling edge of the slot's last bit.

Top module: `pcm_slot_serdes`

## Requirements
- R1: While reset is asserted and after it is released, pcm_doe, pcm_dout and every rx_valid bit are 0 until a slot owned by an enabled channel begins.
- R2: pcm_doe stays 0 for every bit of a slot that matches no enabled channel's cfg_slot. A disabled channel whose slot matches neither drives the line nor raises rx_valid nor changes its rx_sample.
- R3: In an owned slot, pcm_doe goes to 1 on the rising strobe of bit 0 and stays 1 through bit 15. It returns to 0 on the falling strobe of bit 15, before the next slot's rising strobe.
- R4: With the default format (cfg_lsb_first=0, cfg_right_just=0, cfg_fill=0), slot bit k carries word bit 15-k of the word {sample[12:0], 3'b000}. The sample's most significant bit is therefore the first bit of the slot.
- R5: With cfg_lsb_first=1, the 13 sample bits are sent starting with sample[0] and ending with sample[12].
- R6: With cfg_right_just=1, the three spare bits take slot bits 0 to 2 and the sample takes slot bits 3 to 15.
- R7: The spare bits follow cfg_fill, where code 0 gives 000, code 1 gives 111, code 2 gives three copies of sample[12], and code 3 gives cfg_fill_const, whose bit 2 is sent first.
- R8: Receive data is sampled on each falling strobe of an owned slot. After the falling strobe of bit 15, the 13 sample bits are taken with the channel's own placement and bit order, the spare bits are dropped, and the result is written to that channel's rx_sample field. rx_valid for that channel pulses for exactly one clock, and at most one rx_valid bit is high at a time.
- R9: The transmit sample is taken from tx_sample at the rising strobe of bit 0. Changing tx_sample later in the slot does not alter the bits sent in that slot.
- R10: pcm_dout changes only on a clock where rise_stb is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rise_stb | input | 1 | One-cycle mark of a bit-clock rising edge |
| fall_stb | input | 1 | One-cycle mark of a bit-clock falling edge |
| slot_num | input | SLOT_W | Current slot index, held for the whole bit |
| bit_num | input | 4 | Bit position within the slot, 0 is first |
| pcm_din | input | 1 | Serial receive data |
| tx_sample | input | NUM_CH*13 | Transmit sample per channel, channel 0 in the low bits |
| cfg_en | input | NUM_CH | Per-channel enable |
| cfg_slot | input | NUM_CH*SLOT_W | Slot assigned to each channel |
| cfg_lsb_first | input | NUM_CH | 1 selects least significant bit first |
| cfg_right_just | input | NUM_CH | 1 puts the sample at the end of the slot |
| cfg_fill | input | NUM_CH*2 | Spare-bit fill code per channel |
| cfg_fill_const | input | NUM_CH*3 | Programmed fill value per channel |
| pcm_dout | output | 1 | Serial transmit data |
| pcm_doe | output | 1 | Output enable, 0 means the pad is high-impedance |
| rx_sample | output | NUM_CH*13 | Last received sample per channel |
| rx_valid | output | NUM_CH | One-cycle pulse when rx_sample of a channel is updated |

## Verification
A table of eight formats runs through one owned slot each. The table covers the default layout, each fill code, a sign fill with both sign values, the right-placed layout, least-significant-first order, and both combined. Each sample is chosen so that a swapped bit order, a misplaced spare field or a wrong fill code gives a different word. The receive words carry non-zero spare bits, which shows that they are dropped. Directed slots then use an unowned slot, a disabled channel, channels 1 and 2 on other slots (to catch a write to the wrong channel's field), a transmit value changed in the middle of the slot, and back-to-back owned slots that check the release edge.

// File: rtl/pcm_slot_pkg.sv
// Shared constants, fill-code type and bit helpers for the PCM slot serdes.
// Assumes a fixed 16-bit slot carrying a 13-bit narrowband sample.
package pcm_slot_pkg;
    localparam int SAMPLE_W  = 13;
    localparam int SLOT_BITS = 16;
    localparam int FILL_W    = SLOT_BITS - SAMPLE_W;
    localparam int BIT_W     = $clog2(SLOT_BITS);

    typedef enum logic [1:0] {
        FILL_ZERO  = 2'd0,
        FILL_ONE   = 2'd1,
        FILL_SIGN  = 2'd2,
        FILL_CONST = 2'd3
    } fill_mode_t;

    // Reverse the order of the sample bits.
    function automatic logic [SAMPLE_W-1:0] flip_sample(input logic [SAMPLE_W-1:0] s);
        logic [SAMPLE_W-1:0] r;
        for (int i = 0; i < SAMPLE_W; i++) r[i] = s[SAMPLE_W-1-i];
        return r;
    endfunction
endpackage

// File: rtl/pcm_slot_match.sv
// Finds the enabled channel whose slot equals the current slot number.
// If two channels claim one slot, the lowest channel index wins.
module pcm_slot_match #(
    parameter int NUM_CH = 3,
    parameter int SLOT_W = 4,
    parameter int CH_W   = 2
) (
    input  logic [NUM_CH-1:0]        cfg_en,
    input  logic [NUM_CH*SLOT_W-1:0] cfg_slot,
    input  logic [SLOT_W-1:0]        slot_num,
    output logic                     hit,
    output logic [CH_W-1:0]          owner
);
    // Priority search from the top so that the lowest index wins.
    always_comb begin
        hit   = 1'b0;
        owner = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (cfg_en[i] && (cfg_slot[i*SLOT_W +: SLOT_W] == slot_num)) begin
                hit   = 1'b1;
                owner = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/pcm_tx_pack.sv
// Builds the 16-bit transmit word, whose bit 15 goes out in slot bit 0.
// The word is built from a sample, a bit order, a placement and a fill code.
module pcm_tx_pack
    import pcm_slot_pkg::*;
(
    input  logic [SAMPLE_W-1:0]  sample,
    input  logic                 lsb_first,
    input  logic                 right_just,
    input  logic [1:0]           fill_code,
    input  logic [FILL_W-1:0]    fill_const,
    output logic [SLOT_BITS-1:0] word
);
    logic [SAMPLE_W-1:0] seq;
    logic [FILL_W-1:0]   fill;

    // Put the sample bits into wire order.
    always_comb seq = lsb_first ? flip_sample(sample) : sample;

    // Pick the spare-bit pattern.
    always_comb begin
        unique case (fill_mode_t'(fill_code))
            FILL_ZERO:  fill = '0;
            FILL_ONE:   fill = '1;
            FILL_SIGN:  fill = {FILL_W{sample[SAMPLE_W-1]}};
            default:    fill = fill_const;
        endcase
    end

    // Place the sample ahead of or behind the spare field.
    always_comb word = right_just ? {fill, seq} : {seq, fill};
endmodule

// File: rtl/pcm_rx_unpack.sv
// Takes the 13 sample bits out of a received 16-bit word (first bit in bit 15).
// The spare bits are dropped.
module pcm_rx_unpack
    import pcm_slot_pkg::*;
(
    input  logic [SLOT_BITS-1:0] word,
    input  logic                 lsb_first,
    input  logic                 right_just,
    output logic [SAMPLE_W-1:0]  sample
);
    logic [SAMPLE_W-1:0] seq;

    // Select the sample field according to its placement.
    always_comb seq = right_just ? word[SAMPLE_W-1:0] : word[SLOT_BITS-1:FILL_W];

    // Undo the wire bit order.
    always_comb sample = lsb_first ? flip_sample(seq) : seq;
endmodule

// File: rtl/pcm_slot_serdes.sv
// Top of the PCM slot serializer/deserializer.
// Assumes that the timing inputs come from a frame timing unit: single-cycle
// rise/fall strobes that never coincide, and a slot_num/bit_num that is held
// from one rising strobe to the next. pcm_dout is meaningful only while pcm_doe is 1.
module pcm_slot_serdes
    import pcm_slot_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int SLOT_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rise_stb,
    input  logic                          fall_stb,
    input  logic [SLOT_W-1:0]             slot_num,
    input  logic [3:0]                    bit_num,
    input  logic                          pcm_din,
    input  logic [NUM_CH*13-1:0]          tx_sample,
    input  logic [NUM_CH-1:0]             cfg_en,
    input  logic [NUM_CH*SLOT_W-1:0]      cfg_slot,
    input  logic [NUM_CH-1:0]             cfg_lsb_first,
    input  logic [NUM_CH-1:0]             cfg_right_just,
    input  logic [NUM_CH*2-1:0]           cfg_fill,
    input  logic [NUM_CH*3-1:0]           cfg_fill_const,
    output logic                          pcm_dout,
    output logic                          pcm_doe,
    output logic [NUM_CH*13-1:0]          rx_sample,
    output logic [NUM_CH-1:0]             rx_valid
);
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

    logic                  hit;
    logic [CH_W-1:0]       owner;
    logic [SLOT_BITS-1:0]  tx_word;
    logic [SLOT_BITS-1:0]  word_q;
    logic [CH_W-1:0]       owner_q;
    logic                  act_q;
    logic                  doe_q;
    logic                  dout_q;
    logic [SLOT_BITS-2:0]  rx_sr;
    logic [SAMPLE_W-1:0]   rx_word_sample;
    logic [SAMPLE_W-1:0]   rx_data_q [NUM_CH];
    logic [NUM_CH-1:0]     rx_valid_q;
    logic                  last_fall;

    pcm_slot_match #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .CH_W(CH_W)) i_match (
        .cfg_en   (cfg_en),
        .cfg_slot (cfg_slot),
        .slot_num (slot_num),
        .hit      (hit),
        .owner    (owner)
    );

    pcm_tx_pack i_pack (
        .sample     (tx_sample[owner*SAMPLE_W +: SAMPLE_W]),
        .lsb_first  (cfg_lsb_first[owner]),
        .right_just (cfg_right_just[owner]),
        .fill_code  (cfg_fill[owner*2 +: 2]),
        .fill_const (cfg_fill_const[owner*FILL_W +: FILL_W]),
        .word       (tx_word)
    );

    pcm_rx_unpack i_unpack (
        .word       ({rx_sr, pcm_din}),
        .lsb_first  (cfg_lsb_first[owner_q]),
        .right_just (cfg_right_just[owner_q]),
        .sample     (rx_word_sample)
    );

    always_comb last_fall = fall_stb && (bit_num == LAST_BIT);

    // Slot ownership and transmit word capture at the start of each slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            owner_q <= '0;
            word_q  <= '0;
        end else if (rise_stb && bit_num == '0) begin
            act_q   <= hit;
            owner_q <= owner;
            word_q  <= tx_word;
        end
    end

    // Serial output bit, updated on each rising strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout_q <= 1'b0;
        else if (rise_stb)
            dout_q <= (bit_num == '0) ? (hit && tx_word[SLOT_BITS-1])
                                      : (act_q && word_q[LAST_BIT - bit_num]);
    end

    // Output enable: on at bit 0 of an owned slot, off after the last falling strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            doe_q <= 1'b0;
        else if (rise_stb && bit_num == '0)
            doe_q <= hit;
        else if (last_fall)
            doe_q <= 1'b0;
    end

    // Receive shift register, loaded on falling strobes of an owned slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_sr <= '0;
        else if (fall_stb && act_q)
            rx_sr <= {rx_sr[SLOT_BITS-3:0], pcm_din};
    end

    // Sample hand-off to the owning channel with a one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid_q <= '0;
            for (int c = 0; c < NUM_CH; c++) rx_data_q[c] <= '0;
        end else begin
            rx_valid_q <= '0;
            if (last_fall && act_q) begin
                rx_data_q[owner_q]  <= rx_word_sample;
                rx_valid_q[owner_q] <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_rx_out
        assign rx_sample[g*SAMPLE_W +: SAMPLE_W] = rx_data_q[g];
    end

    assign pcm_dout = dout_q;
    assign pcm_doe  = doe_q;
    assign rx_valid = rx_valid_q;
endmodule

// File: rtl/pcm_slot_serdes_chk.sv
// Timing and protocol checks for pcm_slot_serdes. The checker works only from
// the top module's ports and is attached with the bind below.
module pcm_slot_serdes_chk #(
    parameter int NUM_CH = 3,
    parameter int SLOT_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rise_stb,
    input logic                     fall_stb,
    input logic [SLOT_W-1:0]        slot_num,
    input logic [3:0]               bit_num,
    input logic [NUM_CH-1:0]        cfg_en,
    input logic [NUM_CH*SLOT_W-1:0] cfg_slot,
    input logic                     pcm_dout,
    input logic                     pcm_doe,
    input logic [NUM_CH-1:0]        rx_valid
);
    logic any_own;

    // Independent check of whether any enabled channel claims the current slot.
    always_comb begin
        any_own = 1'b0;
        for (int i = 0; i < NUM_CH; i++)
            if (cfg_en[i] && cfg_slot[i*SLOT_W +: SLOT_W] == slot_num) any_own = 1'b1;
    end

    // R10
    dout_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_stb |=> $stable(pcm_dout));

    // R3
    doe_on_at_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcm_doe) |-> ($past(rise_stb) && $past(bit_num) == 4'd0));

    // R3
    doe_off_at_last_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pcm_doe) |-> (($past(fall_stb) && $past(bit_num) == 4'd15) || $past(rise_stb)));

    // R2
    doe_needs_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcm_doe) |-> $past(any_own));

    // R8
    valid_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_valid));

    // R8
    valid_after_last_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_valid) |-> ($past(fall_stb) && $past(bit_num) == 4'd15));

    // R8
    valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_valid) |=> !(|rx_valid));
endmodule

bind pcm_slot_serdes pcm_slot_serdes_chk #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .slot_num (slot_num),
    .bit_num  (bit_num),
    .cfg_en   (cfg_en),
    .cfg_slot (cfg_slot),
    .pcm_dout (pcm_dout),
    .pcm_doe  (pcm_doe),
    .rx_valid (rx_valid)
);

// File: tb/test_pcm_slot_serdes.sv
// Self-checking bench: a table of formats, then directed slot tests.
module test_pcm_slot_serdes;
    localparam int NUM_CH = 3;
    localparam int SLOT_W = 4;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     rise_stb = 1'b0;
    logic                     fall_stb = 1'b0;
    logic [SLOT_W-1:0]        slot_num = '0;
    logic [3:0]               bit_num = '0;
    logic                     pcm_din = 1'b0;
    logic [NUM_CH*13-1:0]     tx_sample = '0;
    logic [NUM_CH-1:0]        cfg_en = '0;
    logic [NUM_CH*SLOT_W-1:0] cfg_slot = '0;
    logic [NUM_CH-1:0]        cfg_lsb_first = '0;
    logic [NUM_CH-1:0]        cfg_right_just = '0;
    logic [NUM_CH*2-1:0]      cfg_fill = '0;
    logic [NUM_CH*3-1:0]      cfg_fill_const = '0;
    logic                     pcm_dout;
    logic                     pcm_doe;
    logic [NUM_CH*13-1:0]     rx_sample;
    logic [NUM_CH-1:0]        rx_valid;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    pcm_slot_serdes #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) i_pcm_slot_serdes (
        .clk(clk), .rst_n(rst_n), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .slot_num(slot_num), .bit_num(bit_num), .pcm_din(pcm_din),
        .tx_sample(tx_sample), .cfg_en(cfg_en), .cfg_slot(cfg_slot),
        .cfg_lsb_first(cfg_lsb_first), .cfg_right_just(cfg_right_just),
        .cfg_fill(cfg_fill), .cfg_fill_const(cfg_fill_const),
        .pcm_dout(pcm_dout), .pcm_doe(pcm_doe),
        .rx_sample(rx_sample), .rx_valid(rx_valid)
    );

    typedef struct packed {
        logic        lsb;
        logic        rj;
        logic [1:0]  fm;
        logic [2:0]  fc;
        logic [12:0] tx;
        logic [15:0] etx;
        logic [15:0] rxw;
        logic [12:0] erx;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 1'b0, 2'd0, 3'b000, 13'h1ABC, 16'hD5E0, 16'hD5E7, 13'h1ABC},
        '{1'b0, 1'b0, 2'd1, 3'b000, 13'h0123, 16'h091F, 16'h0918, 13'h0123},
        '{1'b0, 1'b0, 2'd2, 3'b000, 13'h1001, 16'h800F, 16'h8008, 13'h1001},
        '{1'b0, 1'b0, 2'd3, 3'b101, 13'h0000, 16'h0005, 16'hFFFA, 13'h1FFF},
        '{1'b0, 1'b1, 2'd0, 3'b000, 13'h1555, 16'h1555, 16'hE555, 13'h0555},
        '{1'b1, 1'b0, 2'd0, 3'b000, 13'h0001, 16'h8000, 16'h0008, 13'h1000},
        '{1'b1, 1'b1, 2'd1, 3'b000, 13'h1000, 16'hE001, 16'h0003, 13'h1800},
        '{1'b0, 1'b0, 2'd2, 3'b000, 13'h0FFF, 16'h7FF8, 16'h7FF8, 13'h0FFF}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One full slot: per bit a rising strobe, a falling strobe and an idle cycle.
    task automatic run_slot(input logic [3:0] s, input logic [15:0] rxw,
                            input logic mid, input logic [12:0] midv,
                            output logic [15:0] txw, output logic doe_any,
                            output logic doe_allon, output logic doe_off_end,
                            output logic [NUM_CH-1:0] vld);
        txw = '0; doe_any = 1'b0; doe_allon = 1'b1; doe_off_end = 1'b0; vld = '0;
        for (int b = 0; b < 16; b++) begin
            slot_num = s; bit_num = 4'(b); rise_stb = 1'b1;
            @(negedge clk);
            rise_stb = 1'b0;
            txw[15-b] = pcm_dout;
            if (pcm_doe) doe_any = 1'b1; else doe_allon = 1'b0;
            if (mid && b == 1) tx_sample[12:0] = midv;
            pcm_din = rxw[15-b]; fall_stb = 1'b1;
            @(negedge clk);
            fall_stb = 1'b0;
            if (b == 15) doe_off_end = !pcm_doe;
            vld |= rx_valid;
            @(negedge clk);
        end
    endtask

    logic [15:0]       txw;
    logic              doe_any, doe_allon, doe_off_end;
    logic [NUM_CH-1:0] vld;

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is asserted
        check("R1 doe in reset", 16'(pcm_doe), 16'h0);
        check("R1 dout in reset", 16'(pcm_dout), 16'h0);
        check("R1 rx_valid in reset", 16'(rx_valid), 16'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 doe after reset", 16'(pcm_doe), 16'h0);

        // Table walk: channel 0 on slot 2, one format per vector (R4 R5 R6 R7 R8 R3).
        cfg_en = 3'b001;
        cfg_slot[3:0] = 4'd2;
        foreach (VEC[i]) begin
            cfg_lsb_first[0]    = VEC[i].lsb;
            cfg_right_just[0]   = VEC[i].rj;
            cfg_fill[1:0]       = VEC[i].fm;
            cfg_fill_const[2:0] = VEC[i].fc;
            tx_sample[12:0]     = VEC[i].tx;
            run_slot(4'd2, VEC[i].rxw, 1'b0, 13'h0, txw, doe_any, doe_allon, doe_off_end, vld);
            check($sformatf("R4 R5 R6 R7 tx word vec %0d", i), txw, VEC[i].etx);
            check($sformatf("R3 doe held vec %0d", i), 16'(doe_allon), 16'h1);
            check($sformatf("R3 doe released vec %0d", i), 16'(doe_off_end), 16'h1);
            check($sformatf("R8 valid vec %0d", i), 16'(vld), 16'h1);
            check($sformatf("R8 rx sample vec %0d", i), 16'(rx_sample[12:0]), 16'(VEC[i].erx));
        end
        cfg_lsb_first = '0; cfg_right_just = '0; cfg_fill = '0; cfg_fill_const = '0;

        // R2: unowned slot keeps the pad released, no receive
        run_slot(4'd7, 16'hFFFF, 1'b0, 13'h0, txw, doe_any, doe_allon, doe_off_end, vld);
        check("R2 unowned slot doe", 16'(doe_any), 16'h0);
        check("R2 unowned slot valid", 16'(vld), 16'h0);

        // R2: disabled channel on a matching slot has no effect
        cfg_en = 3'b000;
        run_slot(4'd2, 16'h0000, 1'b0, 13'h0, txw, doe_any, doe_allon, doe_off_end, vld);
        check("R2 disabled doe", 16'(doe_any), 16'h0);
        check("R2 disabled valid", 16'(vld), 16'h0);
        check("R2 disabled rx kept", 16'(rx_sample[12:0]), 16'h0FFF);

        // R8: channel 1 on slot 5 and channel 2 on slot 0 use their own fields
        cfg_en = 3'b110;
        cfg_slot = {4'd0, 4'd5, 4'd2};
        tx_sample[25:13] = 13'h0AAA;
        tx_sample[38:26] = 13'h1FFF;
        run_slot(4'd5, 16'h1238, 1'b0, 13'h0, txw, doe_any, doe_allon, doe_off_end, vld);
        check("R4 ch1 tx word", txw, 16'h5550);
        check("R8 ch1 valid", 16'(vld), 16'h2);
        check("R8 ch1 rx sample", 16'(rx_sample[25:13]), 16'h0247);
        check("R8 ch0 untouched", 16'(rx_sample[12:0]), 16'h0FFF);
        run_slot(4'd0, 16'hABC0, 1'b0, 13'h0, txw, doe_any, doe_allon, doe_off_end, vld);
        check("R4 ch2 tx word", txw, 16'hFFF8);
        check("R8 ch2 valid", 16'(vld), 16'h4);
        check("R8 ch2 rx sample", 16'(rx_sample[38:26]), 16'h1578);

        // R9: transmit value changed mid-slot does not alter the slot
        cfg_en = 3'b001;
        tx_sample[12:0] = 13'h0F0F;
        run_slot(4'd2, 16'h0, 1'b1, 13'h1111, txw, doe_any, doe_allon, doe_off_end, vld);
        check("R9 tx captured at slot start", txw, 16'h7878);

        // R3: back-to-back owned slots release then re-drive
        cfg_en = 3'b011;
        cfg_slot = {4'd0, 4'd4, 4'd3};
        run_slot(4'd3, 16'h0, 1'b0, 13'h0, txw, doe_any, doe_allon, doe_off_end, vld);
        check("R3 first slot released", 16'(doe_off_end), 16'h1);
        run_slot(4'd4, 16'h0, 1'b0, 13'h0, txw, doe_any, doe_allon, doe_off_end, vld);
        check("R3 second slot driven", 16'(doe_allon), 16'h1);
        check("R8 second slot valid", 16'(vld), 16'h2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule